// File: doc/BRIEF.md
# Redundant Output Minority-Voting Stage

This block sits at the boundary between three replicated logic domains and the device pins. Each domain produces its own copy of an output bus. The block drives a number of external pin copies that the board joins on one shared trace. Each driven pin copy has its own per-bit minority voter. The voter releases the pin to high impedance on every bit where that pin's domain is outvoted by the other two. A single wrong domain therefore takes itself off the trace, and the healthy copies keep driving the correct level.

The number of pin copies is fixed at elaboration time. In the triple arrangement every domain has a pin. In the dual arrangement only domains 0 and 1 have pins, but all three domains still take part in the vote. In the single arrangement one 2-of-3 majority voter feeds one pin that is always enabled. A parameter can add a register stage, in which the pin value and its enable are captured together on the same clock edge.

A small monitor sits alongside the voters. It keeps one sticky flag per domain and a saturating count of the cycles in which the domains disagree. A synchronous clear input resets both.

Top module: `rovs_stage`

## Requirements
- R1: In triple mode, pin slot k carries domain k on bits [k*WIDTH +: WIDTH] of `pin_val_o`. Each bit of `pin_oe_o` in that slot is 1 exactly when that domain bit equals at least one of the other two domains' bits.
- R2: A domain that differs from the other two on a bit has its pin released on that bit. Enabled pins never drive conflicting values, and the value resolved on the trace equals the bitwise 2-of-3 majority.
- R3: In dual mode, slots 0 and 1 carry domains 0 and 1, and their voters compare against all three domains. Slot 2 has value 0 and enable 0. A fault confined to domain 2 leaves both pins fully enabled.
- R4: In single mode, slot 0 carries the bitwise majority of the three domains with every enable bit at 1. Slots 1 and 2 have value 0 and enable 0.
- R5: With REG_OUT=0, the pin value and enable follow the domain inputs in the same cycle. With REG_OUT=1, both appear together one clock edge after the inputs.
- R6: Bit k of `odd_flag_o` becomes 1 after any clock edge at which domain k differs from both other domains on some bit. It then stays 1 until a clear or a reset.
- R7: `dis_cnt_o` increases by one on each clock edge at which any bit is not equal across the three domains. It holds at 65535 instead of wrapping.
- R8: When `clr_i` is high at a clock edge, `odd_flag_o` and `dis_cnt_o` become 0, even if the domains disagree in that cycle.
- R9: While reset is held, `odd_flag_o` and `dis_cnt_o` are 0. With REG_OUT=1, every pin value and enable is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Synchronous clear of the flags and the counter |
| dom0_i | input | WIDTH | Output bus of domain 0 |
| dom1_i | input | WIDTH | Output bus of domain 1 |
| dom2_i | input | WIDTH | Output bus of domain 2 |
| pin_val_o | output | 3*WIDTH | Per-slot pin values, slot k at [k*WIDTH +: WIDTH] |
| pin_oe_o | output | 3*WIDTH | Per-slot, per-bit active-high output enables |
| odd_flag_o | output | 3 | Sticky per-domain outvoted flags |
| dis_cnt_o | output | 16 | Saturating count of disagreement cycles |

## Verification
A voter that enables the wrong pin shows up on the resolved trace as a conflict between enabled pins. This is visible in the same cycle as the fault pattern, or one edge later when the register stage is present. A voter that releases a healthy pin shows up directly in the enable pattern for that cycle. A flag or counter in the wrong state shows up at the next edge after the causing cycle, or at the clear. A saturation fault appears only once the count reaches its ceiling, so the stimulus runs past that point.

// File: rtl/rovs_pkg.sv
package rovs_pkg;

    typedef enum logic [1:0] {
        PIN_TRIPLE = 2'd0,
        PIN_DUAL   = 2'd1,
        PIN_SINGLE = 2'd2
    } pin_mode_e;

    localparam int CNT_W = 16;
    localparam int SLOTS = 3;

    function automatic int pins_of(pin_mode_e m);
        case (m)
            PIN_TRIPLE: return 3;
            PIN_DUAL:   return 2;
            default:    return 1;
        endcase
    endfunction

endpackage

// File: rtl/rovs_minority.sv
module rovs_minority #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] own_i,
    input  logic [WIDTH-1:0] peer_a_i,
    input  logic [WIDTH-1:0] peer_b_i,
    output logic [WIDTH-1:0] en_o
);
    // A bit is released only when it differs from both peers.
    always_comb begin
        en_o = ~((own_i ^ peer_a_i) & (own_i ^ peer_b_i));
    end
endmodule

// File: rtl/rovs_majority.sv
module rovs_majority #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] c_i,
    output logic [WIDTH-1:0] y_o
);
    always_comb begin
        y_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    end
endmodule

// File: rtl/rovs_monitor.sv
module rovs_monitor #(
    parameter int WIDTH = 8,
    parameter int CW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [WIDTH-1:0] d0_i,
    input  logic [WIDTH-1:0] d1_i,
    input  logic [WIDTH-1:0] d2_i,
    output logic [2:0]       odd_o,
    output logic [CW-1:0]    cnt_o
);
    logic [2:0] odd_now;
    logic       any_now;

    always_comb begin
        odd_now[0] = |((d0_i ^ d1_i) & (d0_i ^ d2_i));
        odd_now[1] = |((d1_i ^ d0_i) & (d1_i ^ d2_i));
        odd_now[2] = |((d2_i ^ d0_i) & (d2_i ^ d1_i));
        any_now    = |((d0_i ^ d1_i) | (d0_i ^ d2_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            odd_o <= '0;
            cnt_o <= '0;
        end else if (clr_i) begin
            odd_o <= '0;
            cnt_o <= '0;
        end else begin
            odd_o <= odd_o | odd_now;
            if (any_now && (cnt_o != {CW{1'b1}})) begin
                cnt_o <= cnt_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rovs_stage.sv
module rovs_stage #(
    parameter int                  WIDTH   = 8,
    parameter rovs_pkg::pin_mode_e MODE    = rovs_pkg::PIN_TRIPLE,
    parameter bit                  REG_OUT = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_i,
    input  logic [WIDTH-1:0]             dom0_i,
    input  logic [WIDTH-1:0]             dom1_i,
    input  logic [WIDTH-1:0]             dom2_i,
    output logic [3*WIDTH-1:0]           pin_val_o,
    output logic [3*WIDTH-1:0]           pin_oe_o,
    output logic [2:0]                   odd_flag_o,
    output logic [rovs_pkg::CNT_W-1:0]   dis_cnt_o
);
    localparam int NPIN = rovs_pkg::pins_of(MODE);
    localparam int BUSW = rovs_pkg::SLOTS * WIDTH;

    logic [WIDTH-1:0] dom [3];
    logic [BUSW-1:0]  val_c;
    logic [BUSW-1:0]  oe_c;

    assign dom[0] = dom0_i;
    assign dom[1] = dom1_i;
    assign dom[2] = dom2_i;

    generate
        if (MODE == rovs_pkg::PIN_SINGLE) begin : g_single
            logic [WIDTH-1:0] voted;
            rovs_majority #(.WIDTH(WIDTH)) u_maj (
                .a_i (dom[0]),
                .b_i (dom[1]),
                .c_i (dom[2]),
                .y_o (voted)
            );
            assign val_c = {{(2*WIDTH){1'b0}}, voted};
            assign oe_c  = {{(2*WIDTH){1'b0}}, {WIDTH{1'b1}}};
        end else begin : g_minority
            for (genvar k = 0; k < 3; k++) begin : g_slot
                if (k < NPIN) begin : g_on
                    logic [WIDTH-1:0] en;
                    rovs_minority #(.WIDTH(WIDTH)) u_min (
                        .own_i    (dom[k]),
                        .peer_a_i (dom[(k+1)%3]),
                        .peer_b_i (dom[(k+2)%3]),
                        .en_o     (en)
                    );
                    assign val_c[k*WIDTH +: WIDTH] = dom[k];
                    assign oe_c[k*WIDTH +: WIDTH]  = en;
                end else begin : g_off
                    assign val_c[k*WIDTH +: WIDTH] = '0;
                    assign oe_c[k*WIDTH +: WIDTH]  = '0;
                end
            end
        end

        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pin_val_o <= '0;
                    pin_oe_o  <= '0;
                end else begin
                    pin_val_o <= val_c;
                    pin_oe_o  <= oe_c;
                end
            end
        end else begin : g_comb
            assign pin_val_o = val_c;
            assign pin_oe_o  = oe_c;
        end
    endgenerate

    rovs_monitor #(.WIDTH(WIDTH), .CW(rovs_pkg::CNT_W)) u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .d0_i  (dom0_i),
        .d1_i  (dom1_i),
        .d2_i  (dom2_i),
        .odd_o (odd_flag_o),
        .cnt_o (dis_cnt_o)
    );
endmodule

// File: rtl/rovs_stage_chk.sv
module rovs_stage_chk #(
    parameter int                  WIDTH   = 8,
    parameter rovs_pkg::pin_mode_e MODE    = rovs_pkg::PIN_TRIPLE,
    parameter bit                  REG_OUT = 1'b1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       clr_i,
    input logic [WIDTH-1:0]           dom0_i,
    input logic [WIDTH-1:0]           dom1_i,
    input logic [WIDTH-1:0]           dom2_i,
    input logic [3*WIDTH-1:0]         pin_val_o,
    input logic [3*WIDTH-1:0]         pin_oe_o,
    input logic [2:0]                 odd_flag_o,
    input logic [rovs_pkg::CNT_W-1:0] dis_cnt_o
);
    localparam int NPIN = rovs_pkg::pins_of(MODE);
    localparam logic [3*WIDTH-1:0] USED =
        (NPIN == 3) ? {(3*WIDTH){1'b1}} :
        (NPIN == 2) ? {{WIDTH{1'b0}}, {(2*WIDTH){1'b1}}} :
                      {{(2*WIDTH){1'b0}}, {WIDTH{1'b1}}};

    logic             primed;
    logic [WIDTH-1:0] maj_now, maj_q, maj_ref;
    logic             bad_drive, clash;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed <= 1'b0;
            maj_q  <= '0;
        end else begin
            primed <= 1'b1;
            maj_q  <= maj_now;
        end
    end

    always_comb begin
        maj_now = (dom0_i & dom1_i) | (dom0_i & dom2_i) | (dom1_i & dom2_i);
        maj_ref = REG_OUT ? maj_q : maj_now;
        bad_drive = 1'b0;
        clash     = 1'b0;
        for (int k = 0; k < 3; k++) begin
            bad_drive |= |((pin_val_o[k*WIDTH +: WIDTH] ^ maj_ref) & pin_oe_o[k*WIDTH +: WIDTH]);
            for (int j = k + 1; j < 3; j++) begin
                clash |= |(pin_oe_o[k*WIDTH +: WIDTH] & pin_oe_o[j*WIDTH +: WIDTH] &
                           (pin_val_o[k*WIDTH +: WIDTH] ^ pin_val_o[j*WIDTH +: WIDTH]));
            end
        end
    end

    assert_enabled_is_majority_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (REG_OUT == 1'b0 || primed) |-> !bad_drive);

    assert_no_pin_conflict_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clash);

    assert_unused_slot_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe_o & ~USED) == '0);

    assert_single_always_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == rovs_pkg::PIN_SINGLE && primed) |-> (pin_oe_o[WIDTH-1:0] == {WIDTH{1'b1}}));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !$past(clr_i)) |-> ((odd_flag_o & $past(odd_flag_o)) == $past(odd_flag_o)));

    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !$past(clr_i)) |->
            ((dis_cnt_o == $past(dis_cnt_o)) || (dis_cnt_o == $past(dis_cnt_o) + 1'b1)));

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(clr_i)) |-> (dis_cnt_o == '0 && odd_flag_o == 3'b000));
endmodule

bind rovs_stage rovs_stage_chk #(.WIDTH(WIDTH), .MODE(MODE), .REG_OUT(REG_OUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .dom0_i     (dom0_i),
    .dom1_i     (dom1_i),
    .dom2_i     (dom2_i),
    .pin_val_o  (pin_val_o),
    .pin_oe_o   (pin_oe_o),
    .odd_flag_o (odd_flag_o),
    .dis_cnt_o  (dis_cnt_o)
);

// File: tb/tb_rovs_stage.sv
module tb_rovs_stage;
    localparam int W = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n, clr;
    logic [W-1:0] d0, d1, d2;

    logic [3*W-1:0] t_val, t_oe, u_val, u_oe, s_val, s_oe;
    logic [2:0]     t_flag, u_flag, s_flag;
    logic [15:0]    t_cnt, u_cnt, s_cnt;

    rovs_stage #(.WIDTH(W), .MODE(rovs_pkg::PIN_TRIPLE), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .dom0_i(d0), .dom1_i(d1), .dom2_i(d2),
        .pin_val_o(t_val), .pin_oe_o(t_oe), .odd_flag_o(t_flag), .dis_cnt_o(t_cnt));

    rovs_stage #(.WIDTH(W), .MODE(rovs_pkg::PIN_DUAL), .REG_OUT(1'b0)) dut_dual (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .dom0_i(d0), .dom1_i(d1), .dom2_i(d2),
        .pin_val_o(u_val), .pin_oe_o(u_oe), .odd_flag_o(u_flag), .dis_cnt_o(u_cnt));

    rovs_stage #(.WIDTH(W), .MODE(rovs_pkg::PIN_SINGLE), .REG_OUT(1'b1)) dut_single (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .dom0_i(d0), .dom1_i(d1), .dom2_i(d2),
        .pin_val_o(s_val), .pin_oe_o(s_oe), .odd_flag_o(s_flag), .dis_cnt_o(s_cnt));

    typedef struct {
        logic [W-1:0] a, b, c, maj;
        logic         clr;
    } item_t;

    item_t q[$];
    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: applies a stimulus and pushes its expected item.
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c, input logic cl);
        item_t it;
        @(negedge clk);
        #1;
        d0 = a; d1 = b; d2 = c; clr = cl;
        it.a = a; it.b = b; it.c = c; it.clr = cl;
        it.maj = (a & b) | (a & c) | (b & c);
        q.push_back(it);
    endtask

    // Monitor / scoreboard
    int         m_cnt = 0;
    logic [2:0] m_flag = 3'b000;

    always @(negedge clk) begin
        item_t          it;
        logic [3*W-1:0] e_oe;
        logic [2:0]     odd;
        logic           any, conf;
        logic [W-1:0]   tr;
        string          tag;
        if (q.size() > 0) begin
            it = q.pop_front();
            odd[0] = |((it.a ^ it.b) & (it.a ^ it.c));
            odd[1] = |((it.b ^ it.a) & (it.b ^ it.c));
            odd[2] = |((it.c ^ it.a) & (it.c ^ it.b));
            any    = |((it.a ^ it.b) | (it.a ^ it.c));
            if (it.clr) begin
                m_cnt = 0; m_flag = 3'b000;
            end else begin
                m_flag = m_flag | odd;
                if (any && m_cnt < 65535) m_cnt++;
            end
            // R1: triple-mode values and enables
            e_oe = {~(it.c ^ it.maj), ~(it.b ^ it.maj), ~(it.a ^ it.maj)};
            chk(t_val == {it.c, it.b, it.a} && t_oe == e_oe, "R1", {t_val, t_oe}, {it.c, it.b, it.a, e_oe});
            // R2: resolve the shared trace
            conf = 1'b0; tr = '0;
            for (int b = 0; b < W; b++) begin
                logic seen;
                seen = 1'b0;
                for (int k = 0; k < 3; k++) begin
                    if (t_oe[k*W + b]) begin
                        if (seen && tr[b] != t_val[k*W + b]) conf = 1'b1;
                        tr[b] = t_val[k*W + b];
                        seen = 1'b1;
                    end
                end
                if (!seen) conf = 1'b1;
            end
            chk(!conf && tr == it.maj, "R2", {conf, tr}, {1'b0, it.maj});
            // R3: dual mode
            chk(u_val == {{W{1'b0}}, it.b, it.a} &&
                u_oe == {{W{1'b0}}, ~(it.b ^ it.maj), ~(it.a ^ it.maj)},
                "R3", {u_val, u_oe}, {{W{1'b0}}, it.b, it.a, {W{1'b0}}, ~(it.b ^ it.maj), ~(it.a ^ it.maj)});
            // R4: single mode
            chk(s_val == {{(2*W){1'b0}}, it.maj} && s_oe == {{(2*W){1'b0}}, {W{1'b1}}},
                "R4", {s_val, s_oe}, {{(2*W){1'b0}}, it.maj, {(2*W){1'b0}}, {W{1'b1}}});
            tag = it.clr ? "R8" : "R6";
            chk(t_flag == m_flag && s_flag == m_flag, tag, {t_flag, s_flag}, {m_flag, m_flag});
            tag = it.clr ? "R8" : "R7";
            chk(t_cnt == m_cnt[15:0] && u_cnt == m_cnt[15:0], tag, {t_cnt, u_cnt}, {m_cnt[15:0], m_cnt[15:0]});
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clr = 1'b0; d0 = '0; d1 = '0; d2 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(t_val == '0 && t_oe == '0 && s_oe == '0, "R9", {t_val, t_oe}, 64'd0);
        chk(t_flag == 3'b000 && t_cnt == 16'd0 && u_cnt == 16'd0, "R9", {t_flag, t_cnt}, 64'd0);
        #1 rst_n = 1'b1;

        // agreement patterns
        drive(8'hA5, 8'hA5, 8'hA5, 1'b0);
        drive(8'h00, 8'h00, 8'h00, 1'b0);
        drive(8'hFF, 8'hFF, 8'hFF, 1'b0);
        // single faulty domain, each in turn (R2, R3)
        drive(8'h5A ^ 8'h0F, 8'h5A, 8'h5A, 1'b0);
        drive(8'h33, 8'h33 ^ 8'h81, 8'h33, 1'b0);
        drive(8'hC0, 8'hC0, 8'hC0 ^ 8'hFF, 1'b0);
        // faults spread across domains on different bits
        drive(8'h96 ^ 8'h03, 8'h96 ^ 8'h30, 8'h96 ^ 8'hC0, 1'b0);
        // clear with disagreement present (R8)
        drive(8'h01, 8'h00, 8'h00, 1'b1);
        drive(8'h77, 8'h77, 8'h77, 1'b0);

        // R5: combinational and registered timing
        drive(8'h3C, 8'h3C, 8'h3C, 1'b0);
        drive(8'hC3, 8'hC3, 8'hC3, 1'b0);
        #1;
        chk(u_val[W-1:0] == 8'hC3 && t_val[W-1:0] == 8'h3C, "R5", {u_val[W-1:0], t_val[W-1:0]}, {8'hC3, 8'h3C});
        @(posedge clk);
        #1;
        chk(t_val[W-1:0] == 8'hC3 && t_oe[W-1:0] == 8'hFF, "R5", {t_val[W-1:0], t_oe[W-1:0]}, {8'hC3, 8'hFF});

        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] base, f;
            base = W'($urandom);
            f    = W'($urandom);
            case (i % 4)
                0: drive(base ^ f, base, base, 1'b0);
                1: drive(base, base ^ f, base, 1'b0);
                2: drive(base, base, base ^ f, 1'b0);
                default: drive(base ^ (f & 8'h0F), base ^ (f & 8'h30), base ^ (f & 8'hC0), 1'b0);
            endcase
        end

        // saturation of the disagreement counter (R7)
        drive(8'h00, 8'h00, 8'h00, 1'b1);
        for (int i = 0; i < 65540; i++) drive(8'h01, 8'h00, 8'h00, 1'b0);
        repeat (2) @(negedge clk);
        #2;
        chk(t_cnt == 16'hFFFF, "R7", t_cnt, 64'hFFFF);
        drive(8'h00, 8'h00, 8'h00, 1'b1);
        repeat (3) @(negedge clk);
        #2;
        chk(t_cnt == 16'd0 && t_flag == 3'b000, "R8", {t_cnt, t_flag}, 64'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule